// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer and Cycle-Start Monitor

This block keeps the cycle time of a serial-bus link layer. It is a three-field mixed-radix counter. A sub-cycle offset field advances on each qualified tick of the 24.576 MHz time base. A cycle-count field steps each time the offset rolls over, and a seconds field steps each time the cycle count rolls over. Every offset rollover produces a one-clock local cycle event. Firmware can write the whole time value in one step and reads it back through the same word.

The block also watches cycle-start traffic on the bus. It raises a sticky status when two local cycle events in a row pass with no cycle-start packet sent or received. While the node holds the cycle-master role, it raises a second sticky status when a subaction gap is seen after a local cycle event before this node has sent its cycle-start packet. Each status has its own interrupt enable. The interrupt output is the OR of the enabled statuses.

Top module: `cycle_timer_mon`

## Requirements
- R1: The offset field (time_o bits [OFF_W-1:0]) rises by exactly 1 on a clock where tick_i=1, tmr_cap_i=1 and tmr_dis_i=0. On any other clock with no write, all three fields hold.
- R2: An advancing offset at or above OFFSET_MAX-1 returns to 0, and the cycle field (time_o bits [OFF_W+CYC_W-1:OFF_W]) increments on that same clock.
- R3: A cycle field at or above CYCLE_MAX-1 that receives a carry returns to 0 and increments the seconds field (the top SEC_W bits of time_o). The seconds field wraps from 2^SEC_W-1 to 0.
- R4: cyc_evt_o is high for exactly one clock after each offset rollover, in the same clock that time_o first shows offset 0. It does not rise after a write.
- R5: time_wr_i=1 loads time_wdata_i into all three fields at the next edge, with layout {seconds, cycle, offset} from MSB to LSB. A tick in the same clock is ignored. A loaded value at or above its limit rolls over at the next carry.
- R6: Status bit 0 (missing start) sets at a local cycle event when no cs_sent_i or cs_rcvd_i pulse has been seen in the interval that this event ends, and none was seen in the interval before it either.
- R7: Status bit 1 (arbitration failed) sets when master_i=1 and sag_i pulses after a local cycle event, with no cs_sent_i on or before that clock within the window.
- R8: While master_i=0, status bit 1 never sets, and the window from the last local cycle event is dropped.
- R9: Status bits are sticky. Writing 1 on st_clr_i[n] clears bit n. A set in the same clock as a clear wins.
- R10: irq_o is 1 exactly when some status bit is 1 and its st_en_i bit is 1.
- R11: After reset, time_o, cyc_evt_o, st_o and irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick enable (24.576 MHz rate) |
| tmr_dis_i | input | 1 | Timer disable |
| tmr_cap_i | input | 1 | Node is cycle-timer capable |
| master_i | input | 1 | Node acts as cycle master |
| cs_sent_i | input | 1 | Cycle-start packet sent strobe |
| cs_rcvd_i | input | 1 | Cycle-start packet received strobe |
| sag_i | input | 1 | Subaction-gap detected strobe |
| time_wr_i | input | 1 | Load time value |
| time_wdata_i | input | TIME_W | Time value to load |
| st_clr_i | input | 2 | Write-1-to-clear status |
| st_en_i | input | 2 | Interrupt enables per status |
| time_o | output | TIME_W | Current time {seconds, cycle, offset} |
| cyc_evt_o | output | 1 | Local cycle event pulse |
| st_o | output | 2 | Sticky status: bit 0 missing start, bit 1 arbitration failed |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can land in the same clock. The first is a status set from the monitor together with a write-1-to-clear from software. This is provoked by holding the clear of the missing-start bit high through several local cycle events with no start traffic. The status is then judged each cycle: the bit must read 1 right after an event and 0 one clock later. The second is a time write on a clock that also carries a tick. It is judged by the loaded value appearing unchanged, followed by a normal rollover. A long pseudo-random run mixes both collisions with role changes. A bench model built from the requirements checks every field, the event pulse, the status and the interrupt after every clock.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int ST_N    = 2;
  localparam int ST_MISS = 0;
  localparam int ST_ARB  = 1;
  typedef logic [ST_N-1:0] st_vec_t;
endpackage

// File: rtl/ct_digit.sv
module ct_digit #(
  parameter int LIMIT = 4,
  parameter int W     = $clog2(LIMIT)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  logic [W-1:0] val_q;
  logic         last;

  // >= so that an out-of-range loaded value wraps on the next carry
  assign last    = val_q >= W'(LIMIT - 1);
  assign carry_o = inc_i & last;
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= last ? '0 : val_q + 1'b1;
  end

  a_r1_digit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(val_q));
  a_r2_digit_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && last) |=> (val_q == '0));
endmodule

// File: rtl/ct_cs_monitor.sv
module ct_cs_monitor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic master_i,
  input  logic cs_sent_i,
  input  logic cs_rcvd_i,
  input  logic sag_i,
  output logic miss_set_o,
  output logic arb_set_o
);
  logic seen_q, prev_miss_q, armed_q, seen_now;

  assign seen_now   = seen_q | cs_sent_i | cs_rcvd_i;
  assign miss_set_o = evt_i & ~seen_now & prev_miss_q;
  assign arb_set_o  = armed_q & master_i & sag_i & ~cs_sent_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= 1'b0;
      prev_miss_q <= 1'b0;
    end else if (evt_i) begin
      seen_q      <= 1'b0;
      prev_miss_q <= ~seen_now;
    end else begin
      seen_q      <= seen_now;
    end
  end

  // window opens at a local cycle event, closes on own start or the gap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   armed_q <= 1'b0;
    else if (!master_i)            armed_q <= 1'b0;
    else if (evt_i)                armed_q <= 1'b1;
    else if (cs_sent_i || sag_i)   armed_q <= 1'b0;
  end

  a_r8_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !arb_set_o);
  a_r6_miss_on_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_set_o |-> evt_i);
  a_r7_no_arb_after_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_sent_i && !evt_i) |=> !arb_set_o);
endmodule

// File: rtl/ct_status.sv
module ct_status
  import ct_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  st_vec_t set_i,
  input  st_vec_t clr_i,
  input  st_vec_t en_i,
  output st_vec_t stat_o,
  output logic    irq_o
);
  st_vec_t stat_q;

  for (genvar i = 0; i < ST_N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= (stat_q[i] & ~clr_i[i]) | set_i[i];
    end

    a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> stat_q[i]);
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);
endmodule

// File: rtl/cycle_timer_mon.sv
module cycle_timer_mon
  import ct_pkg::*;
#(
  parameter int OFFSET_MAX = 3072,
  parameter int CYCLE_MAX  = 8000,
  parameter int SEC_W      = 7,
  localparam int OFF_W     = $clog2(OFFSET_MAX),
  localparam int CYC_W     = $clog2(CYCLE_MAX),
  localparam int TIME_W    = SEC_W + CYC_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tmr_dis_i,
  input  logic              tmr_cap_i,
  input  logic              master_i,
  input  logic              cs_sent_i,
  input  logic              cs_rcvd_i,
  input  logic              sag_i,
  input  logic              time_wr_i,
  input  logic [TIME_W-1:0] time_wdata_i,
  input  logic [ST_N-1:0]   st_clr_i,
  input  logic [ST_N-1:0]   st_en_i,
  output logic [TIME_W-1:0] time_o,
  output logic              cyc_evt_o,
  output logic [ST_N-1:0]   st_o,
  output logic              irq_o
);
  localparam int CYC_LO = OFF_W;
  localparam int SEC_LO = OFF_W + CYC_W;

  logic             inc_off, carry_off, carry_cyc;
  logic [OFF_W-1:0] off_val;
  logic [CYC_W-1:0] cyc_val;
  logic [SEC_W-1:0] sec_q;
  logic             evt_q;
  logic             miss_set, arb_set;
  st_vec_t          st_set;

  // a write takes the clock; a tick in that clock is dropped
  assign inc_off = tick_i & tmr_cap_i & ~tmr_dis_i & ~time_wr_i;

  ct_digit #(.LIMIT(OFFSET_MAX), .W(OFF_W)) u_off (
    .clk_i, .rst_ni,
    .load_i     (time_wr_i),
    .load_val_i (time_wdata_i[OFF_W-1:0]),
    .inc_i      (inc_off),
    .val_o      (off_val),
    .carry_o    (carry_off)
  );

  ct_digit #(.LIMIT(CYCLE_MAX), .W(CYC_W)) u_cyc (
    .clk_i, .rst_ni,
    .load_i     (time_wr_i),
    .load_val_i (time_wdata_i[SEC_LO-1:CYC_LO]),
    .inc_i      (carry_off),
    .val_o      (cyc_val),
    .carry_o    (carry_cyc)
  );

  // seconds field wraps at its natural power of two
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sec_q <= '0;
    else if (time_wr_i) sec_q <= time_wdata_i[TIME_W-1:SEC_LO];
    else if (carry_cyc) sec_q <= sec_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= carry_off;
  end

  ct_cs_monitor u_mon (
    .clk_i, .rst_ni,
    .evt_i      (evt_q),
    .master_i,
    .cs_sent_i,
    .cs_rcvd_i,
    .sag_i,
    .miss_set_o (miss_set),
    .arb_set_o  (arb_set)
  );

  always_comb begin
    st_set          = '0;
    st_set[ST_MISS] = miss_set;
    st_set[ST_ARB]  = arb_set;
  end

  ct_status u_st (
    .clk_i, .rst_ni,
    .set_i  (st_set),
    .clr_i  (st_clr_i),
    .en_i   (st_en_i),
    .stat_o (st_o),
    .irq_o
  );

  assign time_o    = {sec_q, cyc_val, off_val};
  assign cyc_evt_o = evt_q;

  a_r4_evt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q);
  a_r4_evt_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> (time_o[OFF_W-1:0] == '0));
  a_r5_load_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_wr_i |=> (time_o == $past(time_wdata_i)) && !cyc_evt_o);
  a_r3_sec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!time_wr_i && !carry_cyc) |=> $stable(sec_q));
endmodule

// File: tb/cycle_timer_mon_tb_top.sv
module cycle_timer_mon_tb_top;
  localparam int OM = 4, CM = 3, SW = 2;
  localparam int OW = 2, CW = 2, TW = 6;

  logic clk = 0, rst_ni = 0;
  logic tick = 0, dis = 0, cap = 0, master = 0, sent = 0, rcvd = 0, sag = 0, wr = 0;
  logic [TW-1:0] wdata = '0;
  logic [1:0] clr = '0, en = '0;
  logic [TW-1:0] time_o;
  logic evt_o, irq_o;
  logic [1:0] st_o;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  int m_off = 0, m_cyc = 0, m_sec = 0;
  bit m_evt = 0, m_seen = 0, m_prev = 0, m_armed = 0;
  bit [1:0] m_stat = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  cycle_timer_mon #(.OFFSET_MAX(OM), .CYCLE_MAX(CM), .SEC_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .tmr_dis_i(dis), .tmr_cap_i(cap),
    .master_i(master), .cs_sent_i(sent), .cs_rcvd_i(rcvd), .sag_i(sag),
    .time_wr_i(wr), .time_wdata_i(wdata), .st_clr_i(clr), .st_en_i(en),
    .time_o(time_o), .cyc_evt_o(evt_o), .st_o(st_o), .irq_o(irq_o)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc_cnt);
      finish_run();
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference behaviour from the requirements, applied for the current inputs
  task automatic model_update();
    bit adv, evt_cur, seen_now, miss_s, arb_s, new_evt;
    adv = tick & cap & ~dis;
    evt_cur = m_evt;
    new_evt = 0;
    if (wr) begin
      m_off = int'(wdata[OW-1:0]); m_cyc = int'(wdata[OW+CW-1:OW]); m_sec = int'(wdata[TW-1:OW+CW]);
    end else if (adv) begin
      if (m_off >= OM-1) begin
        m_off = 0; new_evt = 1;
        if (m_cyc >= CM-1) begin m_cyc = 0; m_sec = (m_sec + 1) % (1 << SW); end
        else m_cyc++;
      end else m_off++;
    end
    seen_now = m_seen | sent | rcvd;
    miss_s = evt_cur & ~seen_now & m_prev;
    arb_s = m_armed & master & sag & ~sent;
    if (evt_cur) begin m_prev = ~seen_now; m_seen = 0; end
    else m_seen = seen_now;
    if (!master) m_armed = 0;
    else if (evt_cur) m_armed = 1;
    else if (sent | sag) m_armed = 0;
    m_stat = (m_stat & ~clr) | {arb_s, miss_s};
    m_evt = new_evt;
  endtask

  task automatic compare();
    chk("R1 offset", int'(time_o[OW-1:0]), m_off);
    chk("R2 cycle", int'(time_o[OW+CW-1:OW]), m_cyc);
    chk("R3 seconds", int'(time_o[TW-1:OW+CW]), m_sec);
    chk("R4 event", int'(evt_o), int'(m_evt));
    chk("R6 R9 missing status", int'(st_o[0]), int'(m_stat[0]));
    chk("R7 R8 arbitration status", int'(st_o[1]), int'(m_stat[1]));
    chk("R10 irq", int'(irq_o), int'(|(m_stat & en)));
  endtask

  task automatic step();
    model_update();
    @(posedge clk); #2;
    compare();
  endtask

  task automatic quiet();
    sent = 0; rcvd = 0; sag = 0; wr = 0; clr = 0;
  endtask

  task automatic wait_evt();
    while (!evt_o) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R11 reset time", int'(time_o), 0);
    chk("R11 reset event", int'(evt_o), 0);
    chk("R11 reset status", int'(st_o), 0);
    chk("R11 reset irq", int'(irq_o), 0);
    rst_ni = 1;

    // full sweep of the small configuration, two complete wraps
    cap = 1; tick = 1; en = 2'b11;
    for (int i = 0; i < 2*OM*CM*(1<<SW) + 3; i++) step();

    // set and clear of the missing bit in the same clock (R9)
    clr = 2'b01;
    for (int i = 0; i < 4*OM; i++) begin
      step();
      if (evt_o) begin
        step();
        chk("R9 set wins over clear", int'(st_o[0]), 1);
      end
    end
    clr = 0;

    // hold conditions (R1)
    dis = 1;
    for (int i = 0; i < 6; i++) step();
    chk("R1 hold while disabled", int'(time_o[OW-1:0]), m_off);
    dis = 0; cap = 0;
    for (int i = 0; i < 6; i++) step();
    cap = 1; tick = 0;
    for (int i = 0; i < 4; i++) step();
    tick = 1;

    // load with a tick in the same clock (R5)
    wr = 1; wdata = {2'd2, 2'd1, 2'd3};
    step();
    wr = 0;
    chk("R5 loaded value", int'(time_o), int'({2'd2, 2'd1, 2'd3}));
    chk("R5 no event on load", int'(evt_o), 0);
    step();
    chk("R5 R2 rollover after load", int'(time_o), int'({2'd2, 2'd2, 2'd0}));
    chk("R4 event after rollover", int'(evt_o), 1);
    wr = 1; wdata = {2'd3, 2'd3, 2'd3};
    step();
    wr = 0;
    step();
    chk("R5 R3 out-of-range cycle wraps", int'(time_o), 0);

    // arbitration failure as master (R7)
    master = 1;
    wait_evt();
    clr = 2'b11; step(); clr = 0;
    sag = 1; step(); sag = 0;
    chk("R7 gap before start sets", int'(st_o[1]), 1);
    wait_evt();
    clr = 2'b11; step(); clr = 0;
    sent = 1; step(); sent = 0;
    sag = 1; step(); sag = 0;
    chk("R7 start before gap keeps clear", int'(st_o[1]), 0);

    // not master (R8)
    master = 0;
    wait_evt();
    clr = 2'b11; step(); clr = 0;
    sag = 1; step(); sag = 0;
    chk("R8 slave gap ignored", int'(st_o[1]), 0);

    // interrupt masking (R10)
    master = 1;
    wait_evt();
    step();
    sag = 1; step(); sag = 0; tick = 0;
    for (int e = 0; e < 4; e++) begin
      en = e[1:0];
      #1;
      chk("R10 irq per enable", int'(irq_o), int'(|(st_o & en)));
    end
    tick = 1;

    // long pseudo-random mix
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tick   = lfsr[1:0] != 0;
      dis    = lfsr[6:2] == 0;
      cap    = lfsr[9:7] != 0;
      master = lfsr[10] | lfsr[11];
      sent   = lfsr[15:12] == 0;
      rcvd   = lfsr[19:16] == 0;
      sag    = lfsr[22:20] == 0;
      wr     = lfsr[27:23] == 0;
      wdata  = lfsr[31:26];
      clr    = (lfsr[29:27] == 0) ? lfsr[31:30] : 2'b00;
      en     = lfsr[3:2];
      step();
    end
    quiet();
    step();
    finish_run();
  end
endmodule